// File: doc/BRIEF.md
# I2C High-Speed Mode Tracker

This block runs beside an I2C slave and follows the bus from the slave's point of view to tell whether a high-speed transfer is under way. It cleans the synchronized SCL and SDA lines with a spike filter. It watches the first byte after every start and every repeated start for the high-speed master code. When that code appears, it tells the slave to let the byte pass without an acknowledge. From then on it tracks the bus until the mode is either entered or abandoned. The current mode selects the spike-filter length, so narrower pulses get through once the bus runs fast.

The controller has three states. `ST_NORMAL` is standard/fast operation. `ST_ARMED` means a master code has been seen but no repeated start has followed it yet. `ST_HS` means high-speed operation. The transitions are as follows. A master-code hit moves `ST_NORMAL` to `ST_ARMED`. A repeated start moves `ST_ARMED` to `ST_HS`. A start or a stop moves `ST_ARMED` back to `ST_NORMAL`. A stop moves `ST_HS` back to `ST_NORMAL`. Every other event leaves the state unchanged. Start, repeated-start and stop arrive as one-cycle strobes from the slave's own condition detector. Setting the parameter `HS_EN` to 0 removes high-speed support.

Top module: `i2c_hs_tracker`

## Requirements
- R1: During and after reset, the mode flag is 0, the filter length equals `FAST_LEN`, the ignore-byte strobe is 0, both filtered lines are 1, and the controller is in `ST_NORMAL`.
- R2: A filtered line takes a new raw level only after the raw input has differed from the filtered value for a run of consecutive clocks equal to the current filter length. It changes on the clock edge that ends that run. A shorter pulse never reaches the filtered line.
- R3: The first eight bits after a start or repeated start are sampled on rising edges of the filtered SCL, MSB first. If bits 7..3 are 00001, whatever bits 2..0 are, and the controller is in `ST_NORMAL`, the ignore-byte strobe is high for exactly one cycle: the cycle after the edge that sampled bit 0. Any other first byte raises no strobe.
- R4: After the strobe, the controller is in `ST_ARMED` and the mode flag stays 0.
- R5: A repeated start in `ST_ARMED` sets the mode flag from the following cycle.
- R6: In `ST_HS`, repeated starts and further master-code bytes keep the mode flag at 1 and raise no strobe.
- R7: A stop in `ST_ARMED` or `ST_HS` returns the controller to `ST_NORMAL`, so the mode flag is 0 from the following cycle.
- R8: A plain start or a stop in `ST_ARMED` clears the armed state, so a later repeated start leaves the mode flag at 0.
- R9: The filter length output is `HS_LEN` while the mode flag is 1 and `FAST_LEN` otherwise, and both filters use it. With the default values, a 3-cycle pulse is rejected in standard/fast mode and accepted in high-speed mode.
- R10: With `HS_EN` = 0, the mode flag and the ignore-byte strobe stay 0 under all stimulus.
- R11: Bytes after the first byte of a transfer never raise the strobe, even if they match the master-code pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Synchronized raw SCL |
| sda_i | input | 1 | Synchronized raw SDA |
| start_i | input | 1 | Start condition strobe (not repeated) |
| rstart_i | input | 1 | Repeated start strobe |
| stop_i | input | 1 | Stop condition strobe |
| scl_f_o | output | 1 | Filtered SCL |
| sda_f_o | output | 1 | Filtered SDA |
| hs_mode_o | output | 1 | High-speed mode flag |
| filt_len_o | output | CW | Spike-filter length in clocks now in use |
| skip_byte_o | output | 1 | One-cycle strobe: do not acknowledge the current byte |

## Verification
The hardest state to reach is `ST_ARMED` followed by something other than a repeated start. The bench has to send a complete master-code byte through the filter with its nine clocks, and only then issue a plain start or a stop. After that it must still issue a repeated start to show that nothing is left of the armed state. A behavioural model in the bench follows each event, the filter runs, bit counting and mode changes, and the outputs are compared with it on every clock. A second instance with high-speed support disabled receives the same stimulus.

// File: rtl/i2c_hs_pkg.sv
package i2c_hs_pkg;
    typedef enum logic [1:0] {
        ST_NORMAL = 2'd0,
        ST_ARMED  = 2'd1,
        ST_HS     = 2'd2
    } hs_state_t;

    localparam int          BYTE_BITS = 8;
    localparam int          BIT_CW    = $clog2(BYTE_BITS);
    localparam int          PREFIX_W  = 5;
    localparam logic [4:0]  MC_PREFIX = 5'b00001;
endpackage

// File: rtl/hs_glitch_filter.sv
module hs_glitch_filter #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          raw_i,
    input  logic [CW-1:0] len_i,
    output logic          out_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_o <= 1'b1;
            cnt_q <= '0;
        end else if (raw_i == out_o) begin
            cnt_q <= '0;
        end else if (cnt_q >= len_i - CW'(1)) begin
            out_o <= raw_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // R2: the filtered level only ever moves to the level the raw input held
    p_filter_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_o) |-> (out_o == $past(raw_i)));
endmodule

// File: rtl/hs_byte_watch.sv
module hs_byte_watch
    import i2c_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f_i,
    input  logic sda_f_i,
    input  logic start_i,
    input  logic rstart_i,
    input  logic stop_i,
    output logic hit_o
);
    logic              scl_d_q;
    logic [BIT_CW-1:0] bitcnt_q;
    logic [BYTE_BITS-2:0] sh_q;
    logic              first_q;
    logic              hit_q;
    logic              rise;

    assign rise  = scl_f_i && !scl_d_q;
    assign hit_o = hit_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d_q  <= 1'b1;
            bitcnt_q <= '0;
            sh_q     <= '0;
            first_q  <= 1'b0;
            hit_q    <= 1'b0;
        end else begin
            scl_d_q <= scl_f_i;
            hit_q   <= 1'b0;
            if (start_i || rstart_i) begin
                first_q  <= 1'b1;
                bitcnt_q <= '0;
            end else if (stop_i) begin
                first_q <= 1'b0;
            end else if (rise && first_q) begin
                sh_q     <= {sh_q[BYTE_BITS-3:0], sda_f_i};
                bitcnt_q <= bitcnt_q + BIT_CW'(1);
                if (bitcnt_q == BIT_CW'(BYTE_BITS - 1)) begin
                    first_q <= 1'b0;
                    hit_q   <= (sh_q[BYTE_BITS-2 -: PREFIX_W] == MC_PREFIX);
                end
            end
        end
    end

    // R3: a master-code hit lasts a single cycle
    p_hit_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |=> !hit_q);
    // R11: a hit only follows a sampling edge inside the first byte
    p_hit_after_edge_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit_q |-> ($past(first_q) && $past(scl_f_i) && !$past(scl_d_q)));
endmodule

// File: rtl/hs_mode_fsm.sv
module hs_mode_fsm
    import i2c_hs_pkg::*;
#(
    parameter bit HS_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic start_i,
    input  logic rstart_i,
    input  logic stop_i,
    output logic hs_mode_o,
    output logic skip_o
);
    hs_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NORMAL: if (HS_EN && hit_i)         state_d = ST_ARMED;
            ST_ARMED:  if (stop_i || start_i)      state_d = ST_NORMAL;
                       else if (rstart_i)          state_d = ST_HS;
            ST_HS:     if (stop_i)                 state_d = ST_NORMAL;
            default:                               state_d = ST_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    always_comb begin
        hs_mode_o = (state_q == ST_HS);
        skip_o    = HS_EN && (state_q == ST_NORMAL) && hit_i;
    end

    // R5: the mode flag only rises after a repeated start
    p_enter_on_rstart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_mode_o) |-> $past(rstart_i));
    // R7: a stop always leaves high-speed mode
    p_stop_exits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !hs_mode_o);
    // R4: the strobe is followed by the armed state, not the mode flag
    p_skip_arms_r4: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |=> (!hs_mode_o && state_q == ST_ARMED));
    // R10: without support, no strobe is ever raised
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !HS_EN |-> (!skip_o && !hs_mode_o));
endmodule

// File: rtl/i2c_hs_tracker.sv
module i2c_hs_tracker #(
    parameter int FAST_LEN = 7,
    parameter int HS_LEN   = 2,
    parameter bit HS_EN    = 1'b1,
    localparam int CW      = $clog2(FAST_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          start_i,
    input  logic          rstart_i,
    input  logic          stop_i,
    output logic          scl_f_o,
    output logic          sda_f_o,
    output logic          hs_mode_o,
    output logic [CW-1:0] filt_len_o,
    output logic          skip_byte_o
);
    localparam int NLINES = 2;
    localparam logic [CW-1:0] FAST_L = CW'(FAST_LEN);
    localparam logic [CW-1:0] HS_L   = CW'(HS_LEN);

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    logic              hit;

    assign raw_lines  = {sda_i, scl_i};
    assign scl_f_o    = filt_lines[0];
    assign sda_f_o    = filt_lines[1];
    assign filt_len_o = hs_mode_o ? HS_L : FAST_L;

    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        hs_glitch_filter #(.CW(CW)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (raw_lines[g]),
            .len_i (filt_len_o),
            .out_o (filt_lines[g])
        );
    end

    hs_byte_watch i_watch (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f_i  (scl_f_o),
        .sda_f_i  (sda_f_o),
        .start_i  (start_i),
        .rstart_i (rstart_i),
        .stop_i   (stop_i),
        .hit_o    (hit)
    );

    hs_mode_fsm #(.HS_EN(HS_EN)) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (hit),
        .start_i   (start_i),
        .rstart_i  (rstart_i),
        .stop_i    (stop_i),
        .hs_mode_o (hs_mode_o),
        .skip_o    (skip_byte_o)
    );

    // R9: leaving high-speed mode restores the wide filter on the next cycle
    p_len_follows_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hs_mode_o) |-> (filt_len_o == FAST_L));
endmodule

// File: tb/test_i2c_hs_tracker.sv
`timescale 1ns/1ps
module test_i2c_hs_tracker;
    localparam int FAST = 7;
    localparam int HSL  = 2;
    localparam int CW   = $clog2(FAST + 1);
    localparam int T    = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, st = 1'b0, rs = 1'b0, sp = 1'b0;
    logic scl_f, sda_f, hs, skip;
    logic [CW-1:0] flen;
    logic scl_f2, sda_f2, hs2, skip2;
    logic [CW-1:0] flen2;

    int checks = 0;
    int errors = 0;
    int skips = 0;
    int skips_off = 0;
    bit sda_low_seen;

    always #4 clk = ~clk;

    i2c_hs_tracker #(.FAST_LEN(FAST), .HS_LEN(HSL), .HS_EN(1'b1)) i_i2c_hs_tracker (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .start_i(st),
        .rstart_i(rs), .stop_i(sp), .scl_f_o(scl_f), .sda_f_o(sda_f),
        .hs_mode_o(hs), .filt_len_o(flen), .skip_byte_o(skip));

    i2c_hs_tracker #(.FAST_LEN(FAST), .HS_LEN(HSL), .HS_EN(1'b0)) i_i2c_hs_tracker_off (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .start_i(st),
        .rstart_i(rs), .stop_i(sp), .scl_f_o(scl_f2), .sda_f_o(sda_f2),
        .hs_mode_o(hs2), .filt_len_o(flen2), .skip_byte_o(skip2));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int m_scl, m_sda, run_scl, run_sda, m_prev, m_first, m_nbits, m_byte, m_hit, m_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_scl = 1; m_sda = 1; run_scl = 0; run_sda = 0; m_prev = 1;
            m_first = 0; m_nbits = 0; m_byte = 0; m_hit = 0; m_mode = 0;
        end else begin
            int len, n_scl, n_sda, n_hit, n_mode, rise;
            len = (m_mode == 2) ? HSL : FAST;
            n_scl = m_scl; n_sda = m_sda;
            if (int'(scl) == m_scl) run_scl = 0;
            else if (run_scl >= len - 1) begin n_scl = scl; run_scl = 0; end
            else run_scl++;
            if (int'(sda) == m_sda) run_sda = 0;
            else if (run_sda >= len - 1) begin n_sda = sda; run_sda = 0; end
            else run_sda++;
            rise = (m_scl == 1 && m_prev == 0);
            n_hit = 0;
            if (st || rs) begin m_first = 1; m_nbits = 0; m_byte = 0; end
            else if (sp) m_first = 0;
            else if (rise && m_first == 1) begin
                m_byte = ((m_byte << 1) | m_sda) & 255;
                m_nbits++;
                if (m_nbits == 8) begin
                    m_first = 0;
                    n_hit = ((m_byte >> 3) == 1);
                end
            end
            n_mode = m_mode;
            if (m_mode == 0 && m_hit == 1) n_mode = 1;
            else if (m_mode == 1 && (sp || st)) n_mode = 0;
            else if (m_mode == 1 && rs) n_mode = 2;
            else if (m_mode == 2 && sp) n_mode = 0;
            m_prev = m_scl;
            m_scl = n_scl; m_sda = n_sda; m_hit = n_hit; m_mode = n_mode;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 scl_f", scl_f, m_scl);
            chk("R2 sda_f", sda_f, m_sda);
            chk("R5 hs_mode", hs, (m_mode == 2));
            chk("R9 filt_len", flen, (m_mode == 2) ? HSL : FAST);
            chk("R3 skip", skip, (m_mode == 0 && m_hit == 1));
            chk("R10 off hs_mode", hs2, 0);
            chk("R10 off skip", skip2, 0);
            if (skip) skips++;
            if (skip2) skips_off++;
            if (!sda_f) sda_low_seen = 1'b1;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic strobe(input int which);
        if (which == 0) st = 1'b1; else if (which == 1) rs = 1'b1; else sp = 1'b1;
        tick(1);
        st = 1'b0; rs = 1'b0; sp = 1'b0;
        tick(3);
    endtask

    task automatic send_bit(input logic b);
        scl = 1'b0; tick(T);
        sda = b;    tick(T);
        scl = 1'b1; tick(T);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        send_bit(1'b1);
        scl = 1'b0; tick(T);
        sda = 1'b1; tick(T);
        scl = 1'b1; tick(T);
    endtask

    task automatic pulse_sda(input int n);
        sda_low_seen = 1'b0;
        sda = 1'b0; tick(n);
        sda = 1'b1; tick(12);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        tick(3);
        chk("R1 reset hs", hs, 0);
        chk("R1 reset len", flen, FAST);
        chk("R1 reset skip", skip, 0);
        chk("R1 reset scl_f", scl_f, 1);
        chk("R1 reset sda_f", sda_f, 1);
        rst_n = 1'b1; tick(2);

        pulse_sda(3);  chk("R2 short pulse rejected", sda_low_seen, 0);
        pulse_sda(10); chk("R2 long pulse accepted", sda_low_seen, 1);

        strobe(0); s0 = skips;
        send_byte(8'h0F);
        chk("R3 master code strobe", skips - s0, 1);
        chk("R4 armed, mode still low", hs, 0);
        strobe(1);
        chk("R5 mode after rstart", hs, 1);
        chk("R9 hs filter len", flen, HSL);
        pulse_sda(3); chk("R9 3-cycle pulse accepted in hs", sda_low_seen, 1);
        pulse_sda(1); chk("R2 1-cycle pulse rejected in hs", sda_low_seen, 0);
        s0 = skips;
        send_byte(8'h0C);
        strobe(1);
        chk("R6 mode kept over rstart", hs, 1);
        send_byte(8'h08);
        chk("R6 no strobe in hs", skips - s0, 0);
        strobe(2);
        chk("R7 stop leaves hs", hs, 0);
        chk("R9 fast len restored", flen, FAST);

        strobe(0); s0 = skips;
        send_byte(8'h0A);
        chk("R3 low bits ignored", skips - s0, 1);
        strobe(0); strobe(1);
        chk("R8 start disarms", hs, 0);
        strobe(2);

        strobe(0); s0 = skips;
        send_byte(8'h18);
        chk("R3 non-code byte", skips - s0, 0);
        send_byte(8'h08);
        chk("R11 second byte ignored", skips - s0, 0);
        strobe(2);

        strobe(0); s0 = skips;
        send_byte(8'h09);
        chk("R3 code again", skips - s0, 1);
        strobe(2); strobe(1);
        chk("R8 stop disarms", hs, 0);
        strobe(2);
        chk("R10 disabled instance never strobed", skips_off, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule